// File: doc/BRIEF.md
# Latency-Scheduled Writeback Queue

This block schedules result writeback for a microcoded datapath whose pipeline is exposed to the program. Every step presents a 25-bit instruction word together with the value the functional units produced for it. The block splits the word into two source register indices, an opcode and a destination index, and returns the two source operands from a 128-entry, 32-bit register file. It places the incoming result into a seven-slot circular buffer, at a distance set by the opcode's fixed latency. There are no interlocks. The destination field of an instruction names where the result leaving the buffer in that step goes. It does not name where the instruction's own result will land, so the microcode compiler must place destinations with the latencies in mind.

A vector-output opcode ends a program run. It leaves the buffer and the register file untouched, rewinds the program counter and raises a one-cycle end-of-run flag. When two results are scheduled into the same slot, the later one wins and a collision counter goes up by one.

Top module: `lat_wb_sched`

## Requirements
- R1: While reset is high, and just after it, the program counter and the collision count are 0, the end-of-run flag is low, every register reads 0 and no result is pending.
- R2: Instruction word fields: source A is bits [24:18], source B is [17:11], the opcode is [10:7] and the destination is [6:0]. The source outputs show the registers named by the current word.
- R3: A result issued with opcode code c retires on the L-th later advancing step. L is 5 for codes 1 and 2, 7 for code 3, 2 for codes 4 and 5, 3 for code 6, 4 for codes 8 and 9, and 2 for codes 10 to 15.
- R4: Destination 0 writes nothing, and register 0 always reads 0.
- R5: A slot is cleared to 0 once it retires. A later retirement from that slot, with no new result in it, writes 0.
- R6: Opcode 0 (NOP) schedules no result. Its input value never reaches a register.
- R7: Opcode 7 (vector output) retires nothing and does not advance the buffer. It sets the program counter to 0 and raises the end-of-run flag for exactly the cycle after the step.
- R8: A result scheduled into a slot that already holds a pending result replaces it, and the collision count rises by one.
- R9: A latency-7 result lands in the slot that is retiring in the same step. It survives that step and is not counted as a collision.
- R10: Register reads happen before writes. During a step that writes register r, a source naming r shows the old value. The new value appears after the step.
- R11: With the step input low, the buffer, the registers, the program counter and the collision count hold their values.
- R12: Each advancing step increments the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Execute the presented instruction this cycle |
| instr | input | 25 | Instruction word |
| fu_result | input | 32 | Value the functional units produced for this instruction |
| src_a_data | output | 32 | Register named by source A (combinational) |
| src_b_data | output | 32 | Register named by source B (combinational) |
| pc | output | PC_W | Program counter |
| run_end | output | 1 | One-cycle flag after a vector-output step |
| collisions | output | CNT_W | Count of slot overwrites |

## Verification
The checker watches, on every cycle, that the program counter and the collision count hold while idle. It also checks that the counter steps by exactly one on each advancing step, that a vector-output step rewinds the counter and raises the end-of-run flag, that the flag never appears without such a step, and that register 0 reads zero. Only the bench scenarios can show behaviour that depends on multi-step timing: the exact retirement step for each opcode latency, a result replacing another in the same slot, the latency-7 case at the retiring head, slot clearing across one full turn of the buffer, and the old-value read during a writing step.

// File: rtl/lwq_pkg.sv
package lwq_pkg;
    localparam int DATA_W    = 32;
    localparam int REG_IDX_W = 7;
    localparam int INSTR_W   = 25;
    localparam int LAT_W     = 3;

    typedef enum logic [3:0] {
        OPC_NOP  = 4'd0,  OPC_ADD = 4'd1,  OPC_SUB = 4'd2,  OPC_MUL = 4'd3,
        OPC_ABS  = 4'd4,  OPC_F2I = 4'd5,  OPC_I2F = 4'd6,  OPC_VOUT = 4'd7,
        OPC_SIN  = 4'd8,  OPC_COS = 4'd9,  OPC_GT  = 4'd10, OPC_EQ  = 4'd11,
        OPC_MOV  = 4'd12, OPC_SEL = 4'd13, OPC_SGN = 4'd14, OPC_RSQ = 4'd15
    } opc_e;

    typedef struct packed {
        logic [REG_IDX_W-1:0] src_a;
        logic [REG_IDX_W-1:0] src_b;
        opc_e                 opc;
        logic [REG_IDX_W-1:0] dst;
    } instr_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } slot_t;

    function automatic logic [LAT_W-1:0] op_latency(opc_e op);
        case (op)
            OPC_MUL:                    return 3'd7;
            OPC_ADD, OPC_SUB:           return 3'd5;
            OPC_SIN, OPC_COS:           return 3'd4;
            OPC_I2F:                    return 3'd3;
            OPC_NOP, OPC_VOUT:          return 3'd0;
            default:                    return 3'd2;
        endcase
    endfunction
endpackage

// File: rtl/lwq_slots.sv
module lwq_slots
    import lwq_pkg::*;
#(
    parameter int DEPTH = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              ins_en,
    input  logic [LAT_W-1:0]  ins_lat,
    input  logic [DATA_W-1:0] ins_data,
    output logic [DATA_W-1:0] head_data,
    output logic              collide
);
    localparam int IDX_W = $clog2(DEPTH);

    slot_t            slots [DEPTH];
    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] head_nx;
    logic [IDX_W-1:0] ins_idx;
    int               sum_v;

    always_comb begin
        sum_v = int'(head) + int'(ins_lat);
        if (sum_v >= DEPTH) sum_v = sum_v - DEPTH;
        ins_idx = IDX_W'(sum_v);
        head_nx = (head == IDX_W'(DEPTH - 1)) ? '0 : head + 1'b1;
    end

    assign head_data = slots[head].data;
    // The head slot is being emptied this step, so landing on it is no clash.
    assign collide   = ins_en && slots[ins_idx].valid && (ins_idx != head);

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (adv) begin
            slots[head] <= '0;
            head        <= head_nx;
            if (ins_en) slots[ins_idx] <= '{valid: 1'b1, data: ins_data};
        end
    end
endmodule

// File: rtl/lwq_regfile.sv
module lwq_regfile
    import lwq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [REG_IDX_W-1:0] ra_idx,
    input  logic [REG_IDX_W-1:0] rb_idx,
    output logic [DATA_W-1:0]    ra_data,
    output logic [DATA_W-1:0]    rb_data
);
    localparam int ENTRIES = 1 << REG_IDX_W;

    logic [DATA_W-1:0] mem [ENTRIES];

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/lat_wb_sched.sv
module lat_wb_sched
    import lwq_pkg::*;
#(
    parameter int DEPTH = 7,
    parameter int PC_W  = 11,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  fu_result,
    output logic [DATA_W-1:0]  src_a_data,
    output logic [DATA_W-1:0]  src_b_data,
    output logic [PC_W-1:0]    pc,
    output logic               run_end,
    output logic [CNT_W-1:0]   collisions
);
    instr_t            ins;
    logic              is_vout;
    logic              adv;
    logic              ins_en;
    logic [DATA_W-1:0] head_data;
    logic              collide;

    assign ins     = instr_t'(instr);
    assign is_vout = (ins.opc == OPC_VOUT);
    assign adv     = step && !is_vout;
    assign ins_en  = adv && (ins.opc != OPC_NOP);

    lwq_slots #(.DEPTH(DEPTH)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .ins_en   (ins_en),
        .ins_lat  (op_latency(ins.opc)),
        .ins_data (fu_result),
        .head_data(head_data),
        .collide  (collide)
    );

    lwq_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (adv && (ins.dst != '0)),
        .wr_idx (ins.dst),
        .wr_data(head_data),
        .ra_idx (ins.src_a),
        .rb_idx (ins.src_b),
        .ra_data(src_a_data),
        .rb_data(src_b_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc         <= '0;
            run_end    <= 1'b0;
            collisions <= '0;
        end else begin
            run_end <= step && is_vout;
            if (step) pc <= is_vout ? '0 : pc + 1'b1;
            if (collide) collisions <= collisions + 1'b1;
        end
    end
endmodule

// File: rtl/lwq_sched_chk.sv
module lwq_sched_chk #(
    parameter int PC_W  = 11,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             step,
    input logic [24:0]      instr,
    input logic [31:0]      src_a_data,
    input logic [PC_W-1:0]  pc,
    input logic             run_end,
    input logic [CNT_W-1:0] collisions
);
    logic vout_step;
    assign vout_step = step && (instr[10:7] == 4'd7);

    a_r7_vout_rewinds: assert property (@(posedge clk) disable iff (rst)
        vout_step |=> (pc == '0) && run_end);

    a_r7_end_needs_vout: assert property (@(posedge clk) disable iff (rst)
        run_end |-> $past(vout_step));

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc) && $stable(collisions));

    a_r12_pc_counts: assert property (@(posedge clk) disable iff (rst)
        (step && !vout_step) |=> pc == $past(pc) + 1'b1);

    a_r8_count_by_one: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (collisions == $past(collisions)) ||
                 (collisions == $past(collisions) + 1'b1));

    a_r4_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (instr[24:18] == 7'd0) |-> (src_a_data == 32'd0));
endmodule

bind lat_wb_sched lwq_sched_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/lat_wb_sched_bench.sv
module lat_wb_sched_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [24:0] instr = '0;
    logic [31:0] fu_result = '0;
    logic [31:0] src_a_data, src_b_data;
    logic [10:0] pc;
    logic        run_end;
    logic [15:0] collisions;

    int total = 0;
    int failed = 0;

    always #4 clk = ~clk;

    lat_wb_sched u_lat_wb_sched (.*);

    function automatic logic [24:0] mk(int a, int b, int op, int d);
        return {7'(a), 7'(b), 4'(op), 7'(d)};
    endfunction

    function automatic int exp_lat(int op);
        case (op)
            1, 2:   return 5;
            3:      return 7;
            4, 5:   return 2;
            6:      return 3;
            8, 9:   return 4;
            default: return 2;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step = 1'b0; instr = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_step(int op, int d, logic [31:0] res);
        @(negedge clk);
        instr = mk(0, 0, op, d); fu_result = res; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic rd(int idx, output logic [31:0] v);
        instr = mk(idx, idx, 0, 0);
        #1 v = src_a_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R1 pc", 32'(pc), 0);
        check("R1 collisions", 32'(collisions), 0);
        check("R1 run_end", 32'(run_end), 0);
        rd(77, v); check("R1 reg77", v, 0);
        for (int j = 1; j <= 7; j++) do_step(0, 60 + j, 0);
        for (int j = 1; j <= 7; j++) begin rd(60 + j, v); check("R1 queue empty", v, 0); end
    endtask

    task automatic t_latency();
        logic [31:0] v;
        for (int op = 1; op < 16; op++) begin
            if (op == 7) continue;
            do_reset();
            do_step(op, 0, 32'h1000_0000 + 32'(op));
            for (int j = 1; j <= 8; j++) do_step(0, 10 + j, 0);
            for (int j = 1; j <= 8; j++) begin
                rd(10 + j, v);
                check($sformatf("R3 op%0d step%0d", op, j), v,
                      (j == exp_lat(op)) ? 32'h1000_0000 + 32'(op) : 32'd0);
            end
            check("R12 pc", 32'(pc), 9);
        end
    endtask

    task automatic t_fields();
        do_reset();
        do_step(4, 0, 32'hA5A5_0001);
        do_step(12, 0, 32'h5A5A_0002);
        do_step(0, 5, 0);
        do_step(0, 9, 0);
        instr = mk(5, 9, 0, 0);
        #1;
        check("R2 src A field", src_a_data, 32'hA5A5_0001);
        check("R2 src B field", src_b_data, 32'h5A5A_0002);
        instr = mk(9, 5, 0, 0);
        #1;
        check("R2 src A swap", src_a_data, 32'h5A5A_0002);
        check("R2 src B swap", src_b_data, 32'hA5A5_0001);
    endtask

    task automatic t_dest_zero();
        logic [31:0] v;
        do_reset();
        do_step(4, 0, 32'hCAFE_0004);
        do_step(0, 0, 0);
        do_step(0, 0, 0);
        rd(0, v); check("R4 reg0 stays zero", v, 0);
        instr = mk(3, 0, 0, 0); #1;
        check("R4 reg0 via src B", src_b_data, 0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        do_reset();
        do_step(4, 0, 32'hBEEF_0005);
        do_step(0, 0, 0);
        do_step(0, 31, 0);
        rd(31, v); check("R5 first retire", v, 32'hBEEF_0005);
        for (int j = 4; j <= 9; j++) do_step(0, 0, 0);
        do_step(0, 31, 0);
        rd(31, v); check("R5 slot cleared", v, 0);
    endtask

    task automatic t_nop();
        logic [31:0] v;
        do_reset();
        do_step(0, 0, 32'hDEAD_0006);
        for (int j = 0; j < 7; j++) do_step(0, 40 + j, 32'hDEAD_0006);
        for (int j = 0; j < 7; j++) begin rd(40 + j, v); check("R6 nop no result", v, 0); end
        check("R6 no collision", 32'(collisions), 0);
    endtask

    task automatic t_vout();
        logic [31:0] v;
        do_reset();
        do_step(4, 0, 32'h7777_0007);
        do_step(0, 0, 0);
        check("R12 pc before vout", 32'(pc), 2);
        do_step(7, 23, 32'h1111_1111);
        check("R7 pc rewound", 32'(pc), 0);
        check("R7 run_end high", 32'(run_end), 1);
        @(negedge clk);
        check("R7 run_end one cycle", 32'(run_end), 0);
        do_step(0, 24, 0);
        rd(23, v); check("R7 no retire", v, 0);
        rd(24, v); check("R7 queue not advanced", v, 32'h7777_0007);
        check("R12 pc after vout", 32'(pc), 1);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        do_reset();
        do_step(1, 0, 32'h0000_AAAA);
        do_step(8, 0, 32'h0000_BBBB);
        check("R8 collision counted", 32'(collisions), 1);
        for (int j = 0; j < 3; j++) do_step(0, 0, 0);
        do_step(0, 20, 0);
        do_step(0, 21, 0);
        rd(20, v); check("R8 later wins", v, 32'h0000_BBBB);
        rd(21, v); check("R8 earlier gone", v, 0);
        check("R8 count stays", 32'(collisions), 1);
    endtask

    task automatic t_lat7_head();
        logic [31:0] v;
        do_reset();
        do_step(4, 0, 32'h0000_3333);
        do_step(0, 0, 0);
        do_step(3, 22, 32'h0000_4444);
        for (int j = 0; j < 6; j++) do_step(0, 0, 0);
        do_step(0, 25, 0);
        rd(22, v); check("R9 head retired", v, 32'h0000_3333);
        rd(25, v); check("R9 mul survives", v, 32'h0000_4444);
        check("R9 no collision", 32'(collisions), 0);
    endtask

    task automatic t_rbw();
        logic [31:0] v;
        do_reset();
        do_step(4, 0, 32'h0000_0011);
        do_step(0, 0, 0);
        do_step(4, 33, 32'h0000_0022);
        do_step(0, 0, 0);
        @(negedge clk);
        instr = mk(33, 33, 0, 33); step = 1'b1;
        #1 check("R10 old value during step", src_a_data, 32'h0000_0011);
        @(negedge clk);
        step = 1'b0;
        #1 check("R10 new value after step", src_a_data, 32'h0000_0022);
        rd(33, v); check("R10 reg33", v, 32'h0000_0022);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        do_reset();
        do_step(4, 0, 32'h0000_5151);
        @(negedge clk);
        instr = mk(0, 0, 1, 50); fu_result = 32'hFFFF_FFFF;
        repeat (5) @(negedge clk);
        check("R11 pc held", 32'(pc), 1);
        check("R11 count held", 32'(collisions), 0);
        do_step(0, 0, 0);
        do_step(0, 51, 0);
        rd(50, v); check("R11 no write", v, 0);
        rd(51, v); check("R11 queue held", v, 32'h0000_5151);
        check("R12 pc", 32'(pc), 3);
    endtask

    initial begin
        #(8 * 150000);
        failed++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_fields();
        t_dest_zero();
        t_clear();
        t_nop();
        t_vout();
        t_collision();
        t_lat7_head();
        t_rbw();
        t_idle();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule